// File: doc/BRIEF.md
# Message-In Byte Buffer

This block collects the bytes a target hands back to the initiator during the message-in bus phase and releases them to a transfer that asks for a limited number of bytes. Upstream logic pushes one byte at a time. Each accepted push also carries a two-bit action code, and the last code accepted is the one that counts. When the buffer has been drained completely, that code tells the phase logic what to do next.

A transfer request carries a byte count. The block streams out the smaller of the stored length and the requested count, oldest byte first and one byte per accepted valid/ready handshake. It then pulses a done strobe. If bytes are left over, they move to the front and wait for the next request, and the done strobe reports that the buffer is not yet empty. The block also keeps a copy of the head byte seen at the start of each transfer and a copy of the last byte delivered. A peek output shows the head byte while the message-in phase is active.

The control is a three-state machine:
- `ST_IDLE` takes the START transition into `ST_SEND` on a non-empty request.
- `ST_SEND` follows the NEXT transition back to itself for each byte except the final one.
- After the final byte, `ST_SEND` takes the LAST transition into `ST_DONE`.
- `ST_DONE` takes the RETURN transition back to `ST_IDLE` after one cycle.

Top module: `msgin_buffer`

## Requirements
- R1: The buffer stores up to DEPTH (default 8) bytes and delivers them in push order, oldest first.
- R2: A push is rejected, leaving the contents unchanged, when the buffer is full or a transfer is in progress. `push_err` is high for exactly one cycle, in the cycle after the rejected push.
- R3: A transfer delivers exactly min(stored length, `xfer_count`) bytes on `out_byte`, one per cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_byte` holds its value.
- R4: After a partial transfer, the remaining bytes stay at the front in their original order, and the stored length drops by the number delivered.
- R5: `done_pulse` is high for one cycle, in the cycle after the final byte of a transfer is accepted, and never together with `out_valid`. `done_empty` is 1 in that cycle only when the buffer has been drained to zero.
- R6: The action code is latched from every accepted push and resets to 0. Its encoding is 0 = command phase, 1 = disconnect, 2 = data-out phase, 3 = data-in phase. `done_action` presents the latched code during `done_pulse`.
- R7: `first_byte` is loaded with the head byte when a transfer starts and holds it until the next transfer starts.
- R8: `last_byte` holds the last byte delivered by the most recent transfer.
- R9: `bus_peek` equals the head byte while `in_msg_phase` is 1 and the buffer is not empty. It is 0 when `in_msg_phase` is 0 or the buffer is empty.
- R10: A request with `xfer_count` of 0, or one made while the buffer is empty, delivers nothing, raises no `done_pulse`, and leaves the contents, `first_byte` and `last_byte` unchanged.
- R11: After reset the buffer is empty; `out_valid`, `done_pulse` and `push_err` are 0; and `first_byte`, `last_byte` and the action code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push one byte this cycle |
| push_byte | input | W | Byte to push |
| push_action | input | 2 | Action code accompanying the push |
| push_err | output | 1 | Registered flag: the previous push was rejected |
| xfer_req | input | 1 | Start a transfer (single-cycle strobe) |
| xfer_count | input | CNT_W | Maximum byte count of the transfer |
| out_valid | output | 1 | A byte is offered on `out_byte` |
| out_ready | input | 1 | The consumer accepts the offered byte |
| out_byte | output | W | Byte offered to the consumer |
| done_pulse | output | 1 | Transfer finished |
| done_empty | output | 1 | With `done_pulse`: the buffer is now empty |
| done_action | output | 2 | With `done_pulse`: the latched action code |
| first_byte | output | W | Head byte captured when the last transfer started |
| last_byte | output | W | Final byte delivered by the last transfer |
| in_msg_phase | input | 1 | The bus is currently in the message-in phase |
| bus_peek | output | W | Head byte while in the message-in phase, else 0 |

## Verification
The bench builds the block with its defaults: DEPTH 8, W 8 and CNT_W 8. Because an 8-bit count can ask for up to 255 bytes, one request can exceed what the buffer holds. This exercises clamping to the stored length, and it allows the buffer to be filled to exactly eight bytes so that a ninth push is refused. With the shallow depth, a partial drain followed by a second drain, a stalled consumer, and a push made while a transfer is in progress all fit into short directed scenarios. The bench checks every delivered byte against a queue model of its own.

// File: rtl/msgin_pkg.sv
package msgin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } msgin_state_e;

    typedef enum logic [1:0] {
        ACT_COMMAND    = 2'd0,
        ACT_DISCONNECT = 2'd1,
        ACT_DATA_OUT   = 2'd2,
        ACT_DATA_IN    = 2'd3
    } msgin_act_e;

endpackage

// File: rtl/msgin_store.sv
module msgin_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [W-1:0]     push_data,
    input  logic             pop_en,
    output logic [W-1:0]     head,
    output logic [LEN_W-1:0] len,
    output logic             full
);

    logic [DEPTH-1:0][W-1:0] slot_q;
    logic [DEPTH-1:0][W-1:0] slot_d;
    logic [LEN_W-1:0]        len_q;

    // Each slot either takes its upper neighbour (pop), the pushed byte
    // (when it is the first free slot), or keeps its value.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_top
            assign slot_d[i] = pop_en ? '0 :
                               (push_en && len_q == LEN_W'(i)) ? push_data :
                               slot_q[i];
        end else begin : g_mid
            assign slot_d[i] = pop_en ? slot_q[i+1] :
                               (push_en && len_q == LEN_W'(i)) ? push_data :
                               slot_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            len_q  <= '0;
        end else begin
            slot_q <= slot_d;
            if (pop_en && len_q != '0) begin
                len_q <= len_q - LEN_W'(1);
            end else if (push_en && len_q != LEN_W'(DEPTH)) begin
                len_q <= len_q + LEN_W'(1);
            end
        end
    end

    assign head = slot_q[0];
    assign len  = len_q;
    assign full = (len_q == LEN_W'(DEPTH));

endmodule

// File: rtl/msgin_peek.sv
module msgin_peek #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             in_msg_phase,
    input  logic [W-1:0]     head,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     peek
);

    always_comb begin
        if (in_msg_phase && len != '0) begin
            peek = head;
        end else begin
            peek = '0;
        end
    end

endmodule

// File: rtl/msgin_ctrl.sv
module msgin_ctrl
    import msgin_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int CNT_W = 8,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [1:0]       push_action,
    input  logic             full,
    input  logic [LEN_W-1:0] len,
    input  logic [W-1:0]     head,
    input  logic             xfer_req,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             out_ready,
    output logic             push_en,
    output logic             pop_en,
    output logic             push_err,
    output logic             out_valid,
    output logic             done_pulse,
    output logic             done_empty,
    output logic [1:0]       done_action,
    output logic [W-1:0]     first_byte,
    output logic [W-1:0]     last_byte
);

    msgin_state_e     state_q;
    msgin_state_e     state_d;
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] take;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] len_ext;
    logic             start;
    logic [W-1:0]     first_q;
    logic [W-1:0]     last_q;
    msgin_act_e       act_q;
    logic             err_q;

    assign cnt_ext = CMP_W'(xfer_count);
    assign len_ext = CMP_W'(len);
    assign take    = (cnt_ext < len_ext) ? cnt_ext[LEN_W-1:0] : len;
    assign start   = (state_q == ST_IDLE) && xfer_req &&
                     (xfer_count != '0) && (len != '0);
    assign push_en = push_valid && (state_q == ST_IDLE) && !full;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (out_ready && rem_q == LEN_W'(1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers kept alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            act_q   <= ACT_COMMAND;
            err_q   <= 1'b0;
        end else begin
            err_q <= push_valid && !push_en;
            if (push_en) begin
                act_q <= msgin_act_e'(push_action);
            end
            if (start) begin
                rem_q   <= take;
                first_q <= head;
            end else if (pop_en) begin
                rem_q  <= rem_q - LEN_W'(1);
                last_q <= head;
            end
        end
    end

    // Output logic
    always_comb begin
        out_valid  = 1'b0;
        pop_en     = 1'b0;
        done_pulse = 1'b0;
        done_empty = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND: begin
                out_valid = 1'b1;
                pop_en    = out_ready;
            end
            ST_DONE: begin
                done_pulse = 1'b1;
                done_empty = (len == '0);
            end
            default: ;
        endcase
    end

    assign done_action = act_q;
    assign first_byte  = first_q;
    assign last_byte   = last_q;
    assign push_err    = err_q;

endmodule

// File: rtl/msgin_buffer.sv
module msgin_buffer #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int CNT_W = 8,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [W-1:0]     push_byte,
    input  logic [1:0]       push_action,
    output logic             push_err,
    input  logic             xfer_req,
    input  logic [CNT_W-1:0] xfer_count,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [W-1:0]     out_byte,
    output logic             done_pulse,
    output logic             done_empty,
    output logic [1:0]       done_action,
    output logic [W-1:0]     first_byte,
    output logic [W-1:0]     last_byte,
    input  logic             in_msg_phase,
    output logic [W-1:0]     bus_peek
);

    logic             push_en;
    logic             pop_en;
    logic [W-1:0]     head;
    logic [LEN_W-1:0] buf_len;
    logic             buf_full;

    msgin_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_data (push_byte),
        .pop_en    (pop_en),
        .head      (head),
        .len       (buf_len),
        .full      (buf_full)
    );

    msgin_ctrl #(.DEPTH(DEPTH), .W(W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_valid  (push_valid),
        .push_action (push_action),
        .full        (buf_full),
        .len         (buf_len),
        .head        (head),
        .xfer_req    (xfer_req),
        .xfer_count  (xfer_count),
        .out_ready   (out_ready),
        .push_en     (push_en),
        .pop_en      (pop_en),
        .push_err    (push_err),
        .out_valid   (out_valid),
        .done_pulse  (done_pulse),
        .done_empty  (done_empty),
        .done_action (done_action),
        .first_byte  (first_byte),
        .last_byte   (last_byte)
    );

    msgin_peek #(.DEPTH(DEPTH), .W(W)) u_peek (
        .in_msg_phase (in_msg_phase),
        .head         (head),
        .len          (buf_len),
        .peek         (bus_peek)
    );

    assign out_byte = head;

endmodule

// File: rtl/msgin_buffer_chk.sv
module msgin_buffer_chk #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int CNT_W = 8,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_err,
    input logic             xfer_req,
    input logic [CNT_W-1:0] xfer_count,
    input logic             out_valid,
    input logic             out_ready,
    input logic [W-1:0]     out_byte,
    input logic             done_pulse,
    input logic             done_empty,
    input logic             in_msg_phase,
    input logic [W-1:0]     bus_peek,
    input logic [LEN_W-1:0] buf_len
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_len <= LEN_W'(DEPTH)); // R1

    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && buf_len == LEN_W'(DEPTH) && !out_valid
        |=> push_err && buf_len == LEN_W'(DEPTH)); // R2

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte)); // R3

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> buf_len == $past(buf_len) - LEN_W'(1)); // R4

    AST_DONE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(out_valid && out_ready)); // R5

    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && out_valid)); // R5

    AST_EMPTY_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        done_empty |-> done_pulse && buf_len == '0); // R5

    AST_PEEK_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_msg_phase |-> bus_peek == '0); // R9

    AST_ZERO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_count == '0 && !out_valid && !done_pulse
        |=> !out_valid && $stable(buf_len)); // R10

endmodule

bind msgin_buffer msgin_buffer_chk #(.DEPTH(DEPTH), .W(W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_err     (push_err),
    .xfer_req     (xfer_req),
    .xfer_count   (xfer_count),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_byte     (out_byte),
    .done_pulse   (done_pulse),
    .done_empty   (done_empty),
    .in_msg_phase (in_msg_phase),
    .bus_peek     (bus_peek),
    .buf_len      (buf_len)
);

// File: tb/msgin_buffer_bench.sv
`timescale 1ns/100ps
module msgin_buffer_bench;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       push_valid;
    logic [7:0] push_byte;
    logic [1:0] push_action;
    logic       push_err;
    logic       xfer_req;
    logic [7:0] xfer_count;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_byte;
    logic       done_pulse;
    logic       done_empty;
    logic [1:0] done_action;
    logic [7:0] first_byte;
    logic [7:0] last_byte;
    logic       in_msg_phase;
    logic [7:0] bus_peek;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mq[$];
    logic [1:0] mact = 2'd0;
    logic [7:0] got[64];
    int         got_n;

    always #2.5 clk = ~clk;

    msgin_buffer u_msgin_buffer (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_byte(push_byte), .push_action(push_action),
        .push_err(push_err),
        .xfer_req(xfer_req), .xfer_count(xfer_count),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .done_pulse(done_pulse), .done_empty(done_empty), .done_action(done_action),
        .first_byte(first_byte), .last_byte(last_byte),
        .in_msg_phase(in_msg_phase), .bus_peek(bus_peek)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic [1:0] a);
        bit exp_err;
        exp_err = (mq.size() >= DEPTH);
        @(negedge clk);
        push_valid = 1'b1; push_byte = b; push_action = a;
        @(negedge clk);
        push_valid = 1'b0;
        chk("R2", "push_err", int'(push_err), int'(exp_err));
        if (!exp_err) begin
            mq.push_back(b);
            mact = a;
        end
    endtask

    task automatic peek_check(input string req);
        @(negedge clk);
        in_msg_phase = 1'b1; #1;
        chk(req, "peek in phase", int'(bus_peek), (mq.size() != 0) ? int'(mq[0]) : 0);
        in_msg_phase = 1'b0; #1;
        chk("R9", "peek off phase", int'(bus_peek), 0);
    endtask

    // pat 0: always ready; 1: every other cycle; 2: stall three cycles with a push injected
    task automatic run_xfer(input int cnt, input int pat, input string req);
        int  n_exp;
        bit  seen_done;
        bit  d_empty;
        int  d_act;
        int  c;
        logic [7:0] prev_first;
        logic [7:0] prev_last;
        prev_first = first_byte;
        prev_last  = last_byte;
        n_exp = (cnt < mq.size()) ? cnt : mq.size();
        seen_done = 1'b0; d_empty = 1'b0; d_act = 0; got_n = 0;
        @(negedge clk);
        xfer_req = 1'b1; xfer_count = 8'(cnt); out_ready = 1'b0;
        @(negedge clk);
        xfer_req = 1'b0;
        for (c = 0; c < 40; c++) begin
            if (pat == 0) out_ready = 1'b1;
            else if (pat == 1) out_ready = (c % 2 == 1);
            else out_ready = (c >= 3);
            if (pat == 2 && c == 0) begin
                push_valid = 1'b1; push_byte = 8'hEE; push_action = 2'd0;
            end
            if (pat == 2 && c == 1) begin
                push_valid = 1'b0;
                chk("R2", "push during transfer rejected", int'(push_err), 1);
            end
            #1;
            if (done_pulse) begin
                seen_done = 1'b1; d_empty = done_empty; d_act = int'(done_action);
                break;
            end
            if (out_valid && !out_ready && got_n < mq.size())
                chk("R3", "byte held while stalled", int'(out_byte), int'(mq[got_n]));
            if (out_valid && out_ready) begin
                got[got_n] = out_byte;
                got_n++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(req, "bytes delivered", got_n, n_exp);
        for (int i = 0; i < got_n && i < n_exp; i++)
            chk("R1", "byte order", int'(got[i]), int'(mq[i]));
        if (n_exp == 0) begin
            chk("R10", "no done on empty request", int'(seen_done), 0);
            chk("R10", "first_byte unchanged", int'(first_byte), int'(prev_first));
            chk("R10", "last_byte unchanged", int'(last_byte), int'(prev_last));
        end else begin
            chk("R5", "done seen", int'(seen_done), 1);
            chk("R7", "first_byte", int'(first_byte), int'(mq[0]));
            chk("R8", "last_byte", int'(last_byte), int'(mq[n_exp-1]));
            chk("R5", "done_empty", int'(d_empty), int'(mq.size() == n_exp));
            if (mq.size() == n_exp)
                chk("R6", "done_action", d_act, int'(mact));
            for (int i = 0; i < n_exp; i++) void'(mq.pop_front());
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; push_valid = 1'b0; push_byte = '0; push_action = '0;
        xfer_req = 1'b0; xfer_count = '0; out_ready = 1'b0; in_msg_phase = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "out_valid", int'(out_valid), 0);
        chk("R11", "done_pulse", int'(done_pulse), 0);
        chk("R11", "push_err", int'(push_err), 0);
        chk("R11", "first_byte", int'(first_byte), 0);
        chk("R11", "last_byte", int'(last_byte), 0);
        chk("R11", "done_action", int'(done_action), 0);
        peek_check("R11");
    endtask

    task automatic t_full_drain();
        push(8'h80, 2'd0); push(8'h20, 2'd0); push(8'h5A, 2'd1);
        peek_check("R9");
        run_xfer(8, 0, "R3");
        peek_check("R9");
    endtask

    task automatic t_partial();
        push(8'h11, 2'd0); push(8'h22, 2'd1); push(8'h33, 2'd2);
        push(8'h44, 2'd0); push(8'h55, 2'd3);
        run_xfer(2, 1, "R4");
        peek_check("R4");
        run_xfer(3, 2, "R4");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) push(8'(8'hA0 + i), 2'd2);
        push(8'hFF, 2'd1);
        run_xfer(255, 0, "R3");
        chk("R6", "data-out action kept after rejected push", int'(done_action), 2);
    endtask

    task automatic t_zero();
        push(8'h07, 2'd3); push(8'h08, 2'd0);
        run_xfer(0, 0, "R10");
        peek_check("R10");
        run_xfer(1, 0, "R4");
        run_xfer(1, 0, "R6");
        run_xfer(4, 0, "R10");
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_drain();
        t_partial();
        t_overflow();
        t_zero();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule